// File: doc/BRIEF.md
# Tamper-Triggered Memory Zeroization Controller

This block guards a small on-chip RAM that holds secret data. It watches a group of tamper sensor lines, for example lid microswitches, a tilt switch, a light detector and a break-wire loop. It owns the write port of the RAM. If any sensor line goes high, even for a single clock, the block latches a sticky tamper flag and takes over the write port.

Once the flag is set, the block writes over every word of the RAM several times in a row, and it cannot be stopped. The first passes write a pseudo-random pattern, and each of these passes restarts the generator from a different seed. The last pass writes a fixed decoy image, so the old contents are overwritten with data that carries no meaning.

When the block is idle, host writes and host reads go through it unchanged. The block has two read outputs. The functional read output is used by the logic that owns the secret. The external read output serves debug readback, and a sticky lock can shut it permanently.

Top module: `tamper_zeroize`

## Requirements
- R1: A high level on any bit of `tamperIn` sets an internal tamper flag. A pulse of one clock is enough, and the flag can be cleared only by `rstN`. A level sampled at clock edge k puts the first wipe write (word 0) on the RAM port in the cycle that starts at edge k+3.
- R2: The wipe runs `PASSES` passes. Each pass writes every address from 0 up to `DEPTH`-1, one write per clock, and the passes follow each other with no gap. After the wipe, every address has been written exactly `PASSES` times. Deasserting `tamperIn` does not stop the sequence.
- R3: Every pass except the last writes the state of a 16-bit LFSR. The next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. Word 0 of pass p receives the seed `(16'hACE1 + p*16'h3C5B) mod 2^16`, and each following word receives the next LFSR state.
- R4: The last pass writes 16'hA5A5 to even addresses and 16'h5A5A to odd addresses. The RAM keeps this image after the sequence ends.
- R5: `busy` is high from the cycle after the tamper flag is set until the last write. `done` goes high in the cycle after the last write and stays high.
- R6: While the tamper flag is clear, `hostWrEn`, `hostAddr` and `hostWrData` drive the RAM port unchanged. From the cycle the flag is set, including after `done`, host writes never reach the RAM.
- R7: `funcRdData` equals `ramRdData` when `busy` is low, and equals zero while `busy` is high.
- R8: A high level on `lockSet` at a clock edge sets `locked`, and only `rstN` clears it. `extRdData` equals zero while `locked` or `busy` is high, and equals `ramRdData` otherwise.
- R9: An active-low `rstN` clears the tamper flag, the lock and `done`. If a wipe is in progress, `rstN` stops it, and no write is issued while `rstN` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tamperIn | input | NUM_SENSORS | Asynchronous tamper sensor lines, active high |
| hostAddr | input | ADDR_W | Host address, used for both reads and writes |
| hostWrEn | input | 1 | Host write request |
| hostWrData | input | 16 | Host write data |
| lockSet | input | 1 | Sets the sticky external-readback lock |
| ramRdData | input | 16 | Read data returned by the RAM |
| ramAddr | output | ADDR_W | RAM address |
| ramWrEn | output | 1 | RAM write enable |
| ramWrData | output | 16 | RAM write data |
| funcRdData | output | 16 | Read data for the functional logic |
| extRdData | output | 16 | Read data for the external readback path |
| busy | output | 1 | High while the wipe sequence runs |
| done | output | 1 | Sticky flag: the wipe has finished |
| locked | output | 1 | Sticky flag: the external readback lock is set |

## Verification
The assertions assume that `rstN` is applied only at power-up and is held for at least one clock edge. They make no assumption about the timing of `tamperIn`, so tamper pulses may be one cycle long or may arrive in the middle of a wipe. The bench changes every input on the falling edge, which keeps them stable around the rising edge that samples them. The bench RAM reads before it writes and returns data one cycle after the address.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WIPE, ST_DONE} tz_state_t;

  typedef struct packed {
    logic       loadSeed;
    logic       wipeEn;
    logic       dummyPass;
    logic [7:0] passIdx;
  } tz_strobe_t;

  function automatic word_t lfsrNext(word_t s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic word_t passSeed(logic [7:0] p);
    word_t v;
    v = 16'hACE1 + word_t'(p) * 16'h3C5B;
    return (v == '0) ? 16'h0001 : v;
  endfunction

  function automatic word_t dummyWord(logic oddAddr);
    return oddAddr ? 16'h5A5A : 16'hA5A5;
  endfunction
endpackage

// File: rtl/tz_ctrl.sv
module tz_ctrl
  import tz_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int PASSES      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SENSORS-1:0] tamperIn,
  input  logic                   lockSet,
  input  logic                   addrLast,
  output tz_strobe_t             strobe,
  output logic                   tamperFlag,
  output logic                   busy,
  output logic                   done,
  output logic                   locked
);
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

  logic [NUM_SENSORS-1:0] syncB;
  tz_state_t state, stateNext;
  logic [PASS_W-1:0] passCnt;
  logic finalPass;

  // one two-flop synchronizer per sensor line
  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sync
    logic stageA;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA   <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        stageA   <= tamperIn[g];
        syncB[g] <= stageA;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tamperFlag <= 1'b0;
      locked     <= 1'b0;
    end else begin
      if (|syncB) tamperFlag <= 1'b1;
      if (lockSet) locked <= 1'b1;
    end
  end

  assign finalPass = (passCnt == LAST_PASS);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (tamperFlag) begin
        strobe.loadSeed = 1'b1;
        strobe.passIdx  = 8'd0;
        stateNext       = ST_WIPE;
      end
      ST_WIPE: begin
        strobe.wipeEn    = 1'b1;
        strobe.dummyPass = finalPass;
        if (addrLast) begin
          if (finalPass) stateNext = ST_DONE;
          else begin
            strobe.loadSeed = 1'b1;
            strobe.passIdx  = 8'(passCnt) + 8'd1;
          end
        end
      end
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WIPE && addrLast && !finalPass) passCnt <= passCnt + 1'b1;
    end
  end

  assign busy = tamperFlag && (state != ST_DONE);
  assign done = (state == ST_DONE);

  // R1
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    tamperFlag |=> tamperFlag);
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done && !busy);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WIPE) && !(addrLast && finalPass) |=> (state == ST_WIPE));
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
endmodule

// File: rtl/tz_dpath.sv
module tz_dpath
  import tz_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tz_strobe_t               strobe,
  input  logic                     tamperFlag,
  input  logic                     busy,
  input  logic                     locked,
  input  logic [$clog2(DEPTH)-1:0] hostAddr,
  input  logic                     hostWrEn,
  input  word_t                    hostWrData,
  input  word_t                    ramRdData,
  output logic [$clog2(DEPTH)-1:0] ramAddr,
  output logic                     ramWrEn,
  output word_t                    ramWrData,
  output word_t                    funcRdData,
  output word_t                    extRdData,
  output logic                     addrLast
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wipeAddr;
  word_t lfsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipeAddr <= '0;
      lfsr     <= 16'h0001;
    end else if (strobe.loadSeed) begin
      wipeAddr <= '0;
      lfsr     <= passSeed(strobe.passIdx);
    end else if (strobe.wipeEn) begin
      wipeAddr <= wipeAddr + 1'b1;
      lfsr     <= lfsrNext(lfsr);
    end
  end

  assign addrLast = (wipeAddr == LAST_ADDR);

  always_comb begin
    if (strobe.wipeEn) begin
      ramWrEn   = 1'b1;
      ramAddr   = wipeAddr;
      ramWrData = strobe.dummyPass ? dummyWord(wipeAddr[0]) : lfsr;
    end else begin
      ramWrEn   = hostWrEn && !tamperFlag;
      ramAddr   = hostAddr;
      ramWrData = hostWrData;
    end
  end

  assign funcRdData = busy ? '0 : ramRdData;
  assign extRdData  = (busy || locked) ? '0 : ramRdData;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipeEn && !addrLast |=> wipeAddr == $past(wipeAddr) + ADDR_W'(1));
  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipeEn |-> lfsr != '0);
  // R6
  host_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    tamperFlag && !strobe.wipeEn |-> !ramWrEn);
  // R7
  func_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipeEn |-> funcRdData == '0);
endmodule

// File: rtl/tamper_zeroize.sv
module tamper_zeroize
  import tz_pkg::*;
#(
  parameter int NUM_SENSORS = 4,
  parameter int DEPTH       = 256,
  parameter int PASSES      = 4,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SENSORS-1:0] tamperIn,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic                   hostWrEn,
  input  logic [15:0]            hostWrData,
  input  logic                   lockSet,
  input  logic [15:0]            ramRdData,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic                   ramWrEn,
  output logic [15:0]            ramWrData,
  output logic [15:0]            funcRdData,
  output logic [15:0]            extRdData,
  output logic                   busy,
  output logic                   done,
  output logic                   locked
);
  tz_strobe_t strobe;
  logic tamperFlag, addrLast;

  tz_ctrl #(.NUM_SENSORS(NUM_SENSORS), .PASSES(PASSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tamperIn(tamperIn), .lockSet(lockSet),
    .addrLast(addrLast), .strobe(strobe), .tamperFlag(tamperFlag),
    .busy(busy), .done(done), .locked(locked)
  );

  tz_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tamperFlag(tamperFlag),
    .busy(busy), .locked(locked), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .ramRdData(ramRdData), .ramAddr(ramAddr),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData), .funcRdData(funcRdData),
    .extRdData(extRdData), .addrLast(addrLast)
  );

  // R8
  ext_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> extRdData == '0);
endmodule

// File: tb/tamper_zeroize_tb.sv
module tamper_zeroize_tb;
  localparam int NS = 4, DEPTH = 256, PASSES = 4, AW = 8;
  localparam int TOTAL = PASSES * DEPTH;

  logic clk = 1'b0, rstN = 1'b0, hostWrEn = 1'b0, lockSet = 1'b0;
  logic [NS-1:0] tamperIn = '0;
  logic [AW-1:0] hostAddr = '0, ramAddr;
  logic [15:0] hostWrData = '0, ramRdData = '0, ramWrData, funcRdData, extRdData;
  logic ramWrEn, busy, done, locked;

  int checks = 0, errors = 0;
  logic [15:0] mem [DEPTH];
  int wrCount [DEPTH];

  always #2 clk = ~clk;

  tamper_zeroize #(.NUM_SENSORS(NS), .DEPTH(DEPTH), .PASSES(PASSES)) u_dut (
    .clk(clk), .rstN(rstN), .tamperIn(tamperIn), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .lockSet(lockSet),
    .ramRdData(ramRdData), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .ramWrData(ramWrData), .funcRdData(funcRdData), .extRdData(extRdData),
    .busy(busy), .done(done), .locked(locked)
  );

  // RAM: read-before-write, one-cycle read latency
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= ramWrData;
    ramRdData <= mem[ramAddr];
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] seedOf(int p);
    int v;
    v = 'hACE1 + p * 'h3C5B;
    return v[15:0];
  endfunction

  function automatic logic [15:0] stepOf(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // behavioural reference model
  bit s1, s2, flagM, lockM;
  int phaseM = 0, widx = 0;
  logic [15:0] lfsrM = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; flagM = 0; lockM = 0; phaseM = 0; widx = 0;
    end else begin
      if (phaseM == 1) begin
        widx++;
        if (widx == TOTAL) phaseM = 2;
        else if (widx % DEPTH == 0) lfsrM = seedOf(widx / DEPTH);
        else lfsrM = stepOf(lfsrM);
      end else if (phaseM == 0 && flagM) begin
        phaseM = 1; widx = 0; lfsrM = seedOf(0);
      end
      if (lockSet) lockM = 1;
      flagM = flagM | s2;
      s2 = s1;
      s1 = |tamperIn;
    end
  end

  // per-cycle comparison, 1 ns after the rising edge
  always begin
    @(posedge clk);
    #1;
    if (rstN) begin
      bit wipeE, busyE;
      logic [AW-1:0] aE;
      wipeE = (phaseM == 1);
      busyE = flagM && (phaseM != 2);
      aE = wipeE ? AW'(widx % DEPTH) : hostAddr;
      chk("R5 busy", busy, busyE);
      chk("R5 done", done, phaseM == 2);
      chk("R8 locked", locked, lockM);
      chk("R6 ramWrEn", ramWrEn, wipeE ? 1'b1 : (!flagM && hostWrEn));
      chk("R2 ramAddr", ramAddr, aE);
      if (wipeE) begin
        if (widx / DEPTH == PASSES - 1)
          chk("R4 dummy data", ramWrData, aE[0] ? 16'h5A5A : 16'hA5A5);
        else
          chk("R3 lfsr data", ramWrData, lfsrM);
        wrCount[aE]++;
      end else if (ramWrEn) chk("R6 host data", ramWrData, hostWrData);
      chk("R7 funcRdData", funcRdData, busyE ? 16'h0 : ramRdData);
      chk("R8 extRdData", extRdData, (lockM || busyE) ? 16'h0 : ramRdData);
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic readAt(logic [AW-1:0] a);
    @(negedge clk); hostAddr = a;
    @(posedge clk); #1;
  endtask

  initial begin
    int t0;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; wrCount[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R9 reset state
    chk("R9 busy after reset", busy, 0);
    chk("R9 done after reset", done, 0);
    chk("R9 locked after reset", locked, 0);
    chk("R9 no write after reset", ramWrEn, 0);

    // R6 host writes pass through
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); hostWrEn = 1; hostAddr = AW'(i * 3); hostWrData = 16'h1000 + 16'(i * 7);
    end
    @(negedge clk); hostWrEn = 0;
    readAt(6);
    chk("R7 func read", funcRdData, 16'h100E);
    chk("R8 ext read unlocked", extRdData, 16'h100E);

    // R8 lock
    @(negedge clk); lockSet = 1;
    @(negedge clk); lockSet = 0;
    readAt(6);
    chk("R8 ext read locked", extRdData, 16'h0);
    chk("R7 func read while locked", funcRdData, 16'h100E);

    // R1 one-cycle tamper pulse on sensor 1
    @(negedge clk); tamperIn = 4'b0010;
    @(negedge clk); tamperIn = 4'b0000;
    repeat (4) @(negedge clk);
    chk("R1 busy after pulse", busy, 1);
    // R6 host writes during wipe are ignored, R2 no abort on re-trigger
    hostWrEn = 1; hostAddr = 5; hostWrData = 16'hFFFF;
    repeat (20) @(negedge clk);
    tamperIn = 4'b1000;
    @(negedge clk); tamperIn = 0;
    t0 = 0;
    while (!done && t0 < 3000) begin @(negedge clk); t0++; end
    hostWrEn = 0;
    chk("R5 done reached", done, 1);
    for (int a = 0; a < DEPTH; a++) begin
      chk("R4 final image", mem[a], a[0] ? 16'h5A5A : 16'hA5A5);
      chk("R2 write count", wrCount[a], PASSES);
    end

    // R6 host write after done is ignored
    @(negedge clk); hostWrEn = 1; hostAddr = 7; hostWrData = 16'h1234;
    @(negedge clk); hostWrEn = 0;
    readAt(7);
    chk("R6 write after done blocked", funcRdData, 16'h5A5A);
    chk("R8 ext still locked", extRdData, 16'h0);

    // R9 reset clears lock and flag
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    readAt(4);
    chk("R9 lock cleared", locked, 0);
    chk("R9 ext readable", extRdData, 16'hA5A5);
    chk("R9 done cleared", done, 0);

    // second run on sensor 3, reset mid-wipe
    @(negedge clk); tamperIn = 4'b1000;
    repeat (100) @(negedge clk);
    chk("R1 busy on held sensor", busy, 1);
    rstN = 0;
    #1;
    chk("R9 busy cleared by reset", busy, 0);
    chk("R9 no write in reset", ramWrEn, 0);
    tamperIn = 0;
    @(negedge clk); rstN = 1;
    repeat (6) @(negedge clk);
    chk("R9 stays idle after reset", busy, 0);
    finishRun();
  end
endmodule